// File: doc/BRIEF.md
# Watchdog Timer with Host-Forced Timeout

This block is a watchdog down-counter that the host programs through a small register write port. A configuration register holds the timeout value, an interrupt enable and an output polarity select. Writing it reloads the counter. A prescaled tick input decrements the count. When the count reaches zero, a sticky time-out status flag is set. The flag stays set until the host clears it through the control register.

The host can also force an immediate time-out. It writes a self-clearing force bit in the control register, which zeroes the count and sets the status flag at once. The status flag drives three registered outputs: a level interrupt request gated by the enable, a one-cycle interrupt pulse on each rising edge of the flag, and a general-purpose pin that shows the flag either unchanged or inverted. A timeout value of zero disables counting.

The block has one write port. `wr_sel` = 0 selects the control register and `wr_sel` = 1 selects the configuration register. Control write data: bit 0 is the status bit (write 0 to clear it; a write of 1 has no effect), and bit 2 is force. Configuration write data: bits [CNT_W-1:0] are the timeout value, bit CNT_W is the interrupt enable, and bit CNT_W+1 is the pin inversion.

Top module: `wdog_force`

## Requirements
- R1: After reset the count is 0, the status flag (`ctrl_rd[0]`) is 0, and `irq_lvl`, `irq_pulse` and `gpo` are all 0.
- R2: A configuration write stores the timeout (bits [CNT_W-1:0]), the interrupt enable (bit CNT_W) and the inversion (bit CNT_W+1). At the same clock edge it loads the count with the written timeout value.
- R3: On a cycle with `tick` = 1, the count decrements by one when both the count and the stored timeout are nonzero. Without a tick, the count holds.
- R4: The tick that takes the count from 1 to 0 sets the status flag at that clock edge. Further ticks leave the count at 0.
- R5: With a stored timeout of 0, ticks change neither the count nor the status flag.
- R6: A control write with bit 2 = 1 sets the count to 0 and the status flag to 1 at that edge. Control bit 2 always reads back 0 in `ctrl_rd[2]`.
- R7: The status flag is sticky. A control write with bit 0 = 0 and bit 2 = 0 clears it, and a control write with bit 0 = 1 and bit 2 = 0 leaves it unchanged. Once cleared while the count is 0, the flag stays clear.
- R8: `irq_lvl` equals the status flag ANDed with the interrupt enable, delayed one cycle. It stays 0 while the enable is 0.
- R9: `irq_pulse` is high for exactly one cycle, one cycle after the status flag rises, and only when the interrupt enable is 1.
- R10: `gpo` equals the status flag XORed with the inversion bit, delayed one cycle.
- R11: Priorities within one cycle: force beats a tick, a configuration reload beats a tick, and an expiry beats a status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control, 1 = configuration |
| wr_data | input | CNT_W+2 | Write data |
| ctrl_rd | output | 3 | Control read-back: bit 0 status, bits 1 and 2 read 0 |
| cnt_o | output | CNT_W | Current count |
| irq_lvl | output | 1 | Level interrupt request |
| irq_pulse | output | 1 | One-cycle interrupt event |
| gpo | output | 1 | Status pin with selectable polarity |

## Verification
The assertions check, on every cycle:
- the counter's step rules: hold, decrement, reload and force;
- that the count stays at zero while disabled;
- the stickiness of the status flag, and that only an expiry or a force can raise it;
- the one-cycle relation between the flag and the interrupt and pin outputs.

Only the bench scenarios can show the end-to-end behaviour. They run a full countdown from every timeout value, force a time-out partway through each of them, and resolve same-cycle collisions between writes and ticks. They also sweep every combination of enable, polarity and flag state on the outputs.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CFG  = 1'b1
  } wsel_e;

  localparam int CTRL_W         = 3;
  localparam int CTRL_ST_BIT    = 0;
  localparam int CTRL_FORCE_BIT = 2;
endpackage

// File: rtl/wdf_regs.sv
module wdf_regs
  import wdf_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DW = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             expire,
  output logic             force_p,
  output logic             reload_p,
  output logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] tmo,
  output logic             irq_en,
  output logic             pin_inv,
  output logic             status,
  output logic [CTRL_W-1:0] ctrl_rd
);
  logic ctrl_wr, clr_p;

  assign ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
  assign force_p    = ctrl_wr && wr_data[CTRL_FORCE_BIT];
  assign clr_p      = ctrl_wr && !wr_data[CTRL_ST_BIT] && !wr_data[CTRL_FORCE_BIT];
  assign reload_p   = wr_en && (wr_sel == SEL_CFG);
  assign reload_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo     <= '0;
      irq_en  <= 1'b0;
      pin_inv <= 1'b0;
    end else if (reload_p) begin
      tmo     <= wr_data[CNT_W-1:0];
      irq_en  <= wr_data[CNT_W];
      pin_inv <= wr_data[CNT_W+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   status <= 1'b0;
    else if (force_p || expire) status <= 1'b1;
    else if (clr_p)            status <= 1'b0;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_ST_BIT] = status;
  end

  p_expire_sets_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> status);
  p_force_sets_r6: assert property (@(posedge clk) disable iff (rst)
    force_p |=> status);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status && !clr_p) |=> status);
  p_no_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (!status && !force_p && !expire) |=> !status);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_p && !expire) |=> !status);
endmodule

// File: rtl/wdf_counter.sv
module wdf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             force_p,
  input  logic             reload_p,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step   = tick && (tmo != '0) && (cnt != '0) && !force_p && !reload_p;
  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (force_p)  cnt <= '0;
    else if (reload_p) cnt <= reload_val;
    else if (step)     cnt <= cnt - ONE;
  end

  p_force_zero_r6: assert property (@(posedge clk) disable iff (rst)
    force_p |=> (cnt == '0));
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (reload_p && !force_p) |=> (cnt == $past(reload_val)));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !force_p && !reload_p) |=> $stable(cnt));
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && tmo != '0 && cnt != '0 && !force_p && !reload_p) |=> ((cnt + ONE) == $past(cnt)));
  p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (tmo == '0) |-> (cnt == '0));
endmodule

// File: rtl/wdf_outputs.sv
module wdf_outputs (
  input  logic clk,
  input  logic rst,
  input  logic status,
  input  logic irq_en,
  input  logic pin_inv,
  output logic irq_lvl,
  output logic irq_pulse,
  output logic gpo
);
  logic status_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_d  <= 1'b0;
      irq_lvl   <= 1'b0;
      irq_pulse <= 1'b0;
      gpo       <= 1'b0;
    end else begin
      status_d  <= status;
      irq_lvl   <= status && irq_en;
      irq_pulse <= status && !status_d && irq_en;
      gpo       <= status ^ pin_inv;
    end
  end

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_lvl);
  p_pulse_one_r9: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  p_gpo_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (gpo == $past(status ^ pin_inv)));
endmodule

// File: rtl/wdog_force.sv
module wdog_force
  import wdf_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DW = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_lvl,
  output logic              irq_pulse,
  output logic              gpo
);
  logic             force_p, reload_p, expire, irq_en, pin_inv, status;
  logic [CNT_W-1:0] reload_val, tmo;

  wdf_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .expire(expire), .force_p(force_p), .reload_p(reload_p),
    .reload_val(reload_val), .tmo(tmo), .irq_en(irq_en), .pin_inv(pin_inv),
    .status(status), .ctrl_rd(ctrl_rd)
  );

  wdf_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick), .force_p(force_p), .reload_p(reload_p),
    .reload_val(reload_val), .tmo(tmo), .cnt(cnt_o), .expire(expire)
  );

  wdf_outputs u_outputs (
    .clk(clk), .rst(rst), .status(status), .irq_en(irq_en), .pin_inv(pin_inv),
    .irq_lvl(irq_lvl), .irq_pulse(irq_pulse), .gpo(gpo)
  );
endmodule

// File: tb/wdog_force_bench.sv
`timescale 1ns/1ps
module wdog_force_bench;
  localparam int CW = 4;
  localparam int DW = CW + 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] ctrl_rd;
  logic [CW-1:0] cnt_o;
  logic irq_lvl, irq_pulse, gpo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_force #(.CNT_W(CW)) u_wdog_force (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_rd(ctrl_rd), .cnt_o(cnt_o), .irq_lvl(irq_lvl),
    .irq_pulse(irq_pulse), .gpo(gpo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cfgw(input bit inv, input bit en, input int v);
    return {inv, en, CW'(v)};
  endfunction

  task automatic wr(input bit sel, input logic [DW-1:0] d, input bit t);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 count", cnt_o, 0);
    chk("R1 status", ctrl_rd, 0);
    chk("R1 irq_lvl", irq_lvl, 0);
    chk("R1 irq_pulse", irq_pulse, 0);
    chk("R1 gpo", gpo, 0);

    // full countdown from every timeout value
    for (int v = 1; v < 16; v++) begin
      wr(1'b0, 0, 1'b0);
      wr(1'b1, cfgw(0, 1, v), 1'b0);
      chk("R2 reload", cnt_o, v);
      for (int k = 1; k <= v; k++) begin
        tk(1);
        chk("R3 decrement", cnt_o, v - k);
        chk("R4 status at zero", ctrl_rd[0], (k == v) ? 1 : 0);
        if (v == 15 && k == 5) begin
          idle(3);
          chk("R3 hold without tick", cnt_o, v - k);
        end
      end
      idle(1);
      chk("R8 irq_lvl rises", irq_lvl, 1);
      chk("R9 pulse high", irq_pulse, 1);
      chk("R10 gpo", gpo, 1);
      idle(1);
      chk("R9 pulse one cycle", irq_pulse, 0);
      tk(2);
      chk("R4 count stays zero", cnt_o, 0);
      wr(1'b0, 1, 1'b0);
      chk("R7 write 1 keeps status", ctrl_rd[0], 1);
      wr(1'b0, 0, 1'b0);
      chk("R7 clear", ctrl_rd[0], 0);
      tk(2);
      chk("R7 no re-set at zero", ctrl_rd[0], 0);
      chk("R8 irq_lvl falls", irq_lvl, 0);
    end

    // disabled timer
    wr(1'b0, 0, 1'b0);
    wr(1'b1, cfgw(0, 1, 0), 1'b0);
    tk(5);
    chk("R5 count", cnt_o, 0);
    chk("R5 status", ctrl_rd[0], 0);
    wr(1'b1, cfgw(0, 1, 9), 1'b0);
    tk(2);
    wr(1'b1, cfgw(0, 1, 0), 1'b0);
    tk(12);
    chk("R5 disable mid-count", cnt_o, 0);
    chk("R5 status mid-count", ctrl_rd[0], 0);

    // forced timeout partway through every timeout value
    for (int v = 1; v < 16; v++) begin
      wr(1'b0, 0, 1'b0);
      wr(1'b1, cfgw(0, 1, v), 1'b0);
      tk(v / 2);
      chk("R3 partial count", cnt_o, v - v / 2);
      wr(1'b0, 4, 1'b0);
      chk("R6 force count", cnt_o, 0);
      chk("R6 force status", ctrl_rd[0], 1);
      chk("R6 force reads 0", ctrl_rd[2], 0);
    end

    // same-cycle priorities
    wr(1'b0, 0, 1'b0);
    wr(1'b1, cfgw(0, 1, 6), 1'b0);
    tk(2);
    wr(1'b0, 4, 1'b1);
    chk("R11 force beats tick count", cnt_o, 0);
    chk("R11 force beats tick status", ctrl_rd[0], 1);
    wr(1'b0, 0, 1'b0);
    wr(1'b1, cfgw(0, 1, 3), 1'b0);
    tk(1);
    wr(1'b1, cfgw(0, 1, 7), 1'b1);
    chk("R11 reload beats tick", cnt_o, 7);
    wr(1'b1, cfgw(0, 1, 1), 1'b0);
    wr(1'b0, 0, 1'b1);
    chk("R11 expiry beats clear", ctrl_rd[0], 1);
    chk("R11 expiry count", cnt_o, 0);

    // enable / polarity / status sweep
    for (int en = 0; en < 2; en++)
      for (int inv = 0; inv < 2; inv++)
        for (int st = 0; st < 2; st++) begin
          wr(1'b0, 0, 1'b0);
          wr(1'b1, cfgw(inv[0], en[0], 0), 1'b0);
          idle(2);
          if (st == 1) begin
            wr(1'b0, 4, 1'b0);
            idle(1);
            chk("R9 pulse gated", irq_pulse, en);
            chk("R8 level gated", irq_lvl, en);
            chk("R10 polarity set", gpo, 1 ^ inv);
            idle(1);
            chk("R9 pulse ends", irq_pulse, 0);
          end else begin
            chk("R8 level clear", irq_lvl, 0);
            chk("R10 polarity clear", gpo, inv);
            chk("R9 no pulse", irq_pulse, 0);
          end
        end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule